// File: doc/BRIEF.md
# DMA Acknowledge Tracker and End-of-Process Router

This block sits between a pair of cascaded four-channel DMA controllers and an expansion bus that offers eight DMA channels. It watches the active-low acknowledge line of every channel. From these lines it keeps a record of which single channel currently owns the bus, or that no channel does. From that record it forms the upper bits of the memory address out of per-channel page registers. Channels 0 to 3 make byte transfers and channels 5 to 7 make word transfers.

Memory read and write strobes coming from the controllers pass only while some channel is acknowledged. With no owner, a read returns all ones and a write never reaches memory. The controller's end-of-process state is held in a flag. Each bus channel has its own enable, and the flag is forwarded only to the channel that owns the bus. A channel that is acknowledged while the flag is already set still receives it. Acknowledge line 4 joins the two controllers. It is turned around as the first controller's hold-acknowledge and is never tracked as a channel.

Top module: `dma_ack_router`

## Requirements
- R1: After reset no channel is active, every bus end-of-process output is low, and all page registers read as zero.
- R2: A high-to-low change on acknowledge line n (n not 4) makes n the active channel from the next clock edge. If several lines fall in the same cycle, the lowest-numbered one wins.
- R3: A low-to-high change on the line of the held channel leaves no channel active from the next edge. A release on any other line leaves the held channel unchanged.
- R4: While no channel is active, mem_rd_en and mem_wr_en stay low and dma_rdata is 8'hFF. While a channel is active, the strobes follow the requests and dma_rdata follows mem_rdata_i.
- R5: For active channels 0 to 3 the address is {page byte of that channel, mem_off[15:0]} on 24 bits.
- R6: For active channels 5 to 7 the address is {bits 7:1 of the word-bank page of channel minus 4, mem_off[15:0], 1'b0}.
- R7: The controller end-of-process input is captured at a clock edge. On the following edge, bus_eop[n] goes high if and only if n is active and the captured flag is set. At most one bus_eop bit is ever high.
- R8: If the captured flag is already set when channel n is acknowledged, bus_eop[n] rises two edges after the acknowledge falls. When n is released, bus_eop[n] falls two edges after the release.
- R9: bus_eop[n] stays low while eop_en[n] is low, whatever the flag and the tracking state.
- R10: hold_ack is the inverse of acknowledge line 4 with no register in between. A fall on line 4 never changes the active channel.
- R11: A page write with pg_we high stores pg_wdata at the next edge. pg_addr[2] selects the bank (0: byte channels 0 to 3, 1: word channels 4 to 7) and pg_addr[1:0] selects the channel within the bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dack_n | input | 8 | Active-low per-channel acknowledge lines; bit 4 is the cascade link |
| hold_ack | output | 1 | Hold-acknowledge to the first controller, inverse of dack_n[4] |
| pg_we | input | 1 | Page register write strobe |
| pg_addr | input | 3 | Page register index: bit 2 bank, bits 1:0 channel |
| pg_wdata | input | 8 | Page register write data |
| mem_off | input | 16 | Transfer offset from the controller |
| mem_rd_req | input | 1 | DMA memory read request |
| mem_wr_req | input | 1 | DMA memory write request |
| mem_rdata_i | input | 8 | Data returned by memory |
| mem_addr | output | 24 | Composed memory address |
| mem_rd_en | output | 1 | Gated memory read strobe |
| mem_wr_en | output | 1 | Gated memory write strobe |
| dma_rdata | output | 8 | Read data back to the controller |
| ctl_eop | input | 1 | Controller end-of-process state, active high |
| eop_en | input | 8 | Per-channel end-of-process forwarding enable |
| bus_eop | output | 8 | Per-channel end-of-process to the bus devices |
| act_valid | output | 1 | A channel currently holds the bus |
| act_ch | output | 3 | Number of the active channel, meaningful when act_valid is high |

## Verification
Channel tracking costs one register. act_valid and act_ch, and with them mem_addr, the gated strobes and dma_rdata, settle one clock edge after an acknowledge changes. Those three outputs are combinational from the tracking register, the pages and the live requests. End-of-process adds a capture register and an output register. bus_eop therefore answers two edges after ctl_eop or an acknowledge changes, and one edge after eop_en changes. hold_ack needs no edge at all. The bench drives every input on the falling clock edge and checks on a later falling edge, counted to these latencies. For end-of-process it also checks the intermediate edge, so that an answer one cycle early is caught.

// File: rtl/dar_pkg.sv
package dar_pkg;
  localparam int unsigned DAR_NCH     = 8;
  localparam int unsigned DAR_CASCADE = 4;
  localparam int unsigned DAR_CHW     = $clog2(DAR_NCH);
  typedef logic [DAR_CHW-1:0] dar_ch_t;
endpackage

// File: rtl/dar_chan_track.sv
module dar_chan_track #(
  parameter int unsigned NCH     = 8,
  parameter int unsigned CASCADE = 4,
  localparam int unsigned CHW    = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] dack_n,
  output logic           act_valid,
  output logic [CHW-1:0] act_ch
);
  localparam logic [NCH-1:0] CAS_MASK = NCH'(1) << CASCADE;

  logic [NCH-1:0] dack_q;
  logic [NCH-1:0] falls;
  logic [NCH-1:0] rises;
  logic [CHW-1:0] pick;
  logic           upd_en;
  logic           valid_d;
  logic [CHW-1:0] ch_d;

  // edge detection on the acknowledge lines, cascade excluded from falls
  always_comb begin
    falls = dack_q & ~dack_n & ~CAS_MASK;
    rises = ~dack_q & dack_n;
  end

  // lowest-numbered falling line wins
  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (falls[i]) pick = CHW'(i);
    end
  end

  always_comb begin
    valid_d = act_valid;
    ch_d    = act_ch;
    upd_en  = 1'b0;
    if (|falls) begin
      valid_d = 1'b1;
      ch_d    = pick;
      upd_en  = 1'b1;
    end else if (act_valid && rises[act_ch]) begin
      valid_d = 1'b0;
      upd_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dack_q <= '1;
    end else begin
      dack_q <= dack_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_valid <= 1'b0;
      act_ch    <= '0;
    end else if (upd_en) begin
      act_valid <= valid_d;
      act_ch    <= ch_d;
    end
  end

  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    falls[0] |=> (act_valid && act_ch == '0)); // R2

  AST_HELD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && rises[act_ch] && falls == '0) |=> !act_valid); // R3

  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (falls == '0 && !(act_valid && rises[act_ch])) |=> ($stable(act_valid) && $stable(act_ch))); // R3

  AST_CASCADE_UNTRACKED: assert property (@(posedge clk) disable iff (!rst_n)
    !(act_valid && act_ch == CHW'(CASCADE))); // R10
endmodule

// File: rtl/dar_page_file.sv
module dar_page_file #(
  parameter int unsigned NCH  = 8,
  parameter int unsigned PGW  = 8,
  parameter int unsigned OFFW = 16,
  localparam int unsigned CHW  = $clog2(NCH),
  localparam int unsigned BANK = NCH / 2,
  localparam int unsigned BW   = $clog2(BANK),
  localparam int unsigned AW   = PGW + OFFW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pg_we,
  input  logic [CHW-1:0]  pg_addr,
  input  logic [PGW-1:0]  pg_wdata,
  input  logic            act_valid,
  input  logic [CHW-1:0]  act_ch,
  input  logic [OFFW-1:0] mem_off,
  output logic [AW-1:0]   mem_addr
);
  // byte bank keeps full pages, word bank keeps only the bits it uses
  logic [BANK-1:0][PGW-1:0] pg_byte;
  logic [BANK-1:0][PGW-2:0] pg_word;
  logic [BANK-1:0]          we_byte;
  logic [BANK-1:0]          we_word;
  logic [BW-1:0]            sel;
  logic                     is_word;
  logic [AW-1:0]            byte_addr;
  logic [AW-1:0]            word_addr;

  always_comb begin
    for (int j = 0; j < int'(BANK); j++) begin
      we_byte[j] = pg_we && !pg_addr[CHW-1] && (pg_addr[BW-1:0] == BW'(j));
      we_word[j] = pg_we &&  pg_addr[CHW-1] && (pg_addr[BW-1:0] == BW'(j));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_byte <= '0;
      pg_word <= '0;
    end else begin
      for (int j = 0; j < int'(BANK); j++) begin
        if (we_byte[j]) pg_byte[j] <= pg_wdata;
        if (we_word[j]) pg_word[j] <= pg_wdata[PGW-1:1];
      end
    end
  end

  always_comb begin
    sel       = act_ch[BW-1:0];
    is_word   = act_ch[CHW-1];
    byte_addr = {pg_byte[sel], mem_off};
    word_addr = {pg_word[sel], mem_off, 1'b0};
    if (!act_valid) begin
      mem_addr = '0;
    end else if (is_word) begin
      mem_addr = word_addr;
    end else begin
      mem_addr = byte_addr;
    end
  end

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && act_ch[CHW-1]) |-> !mem_addr[0]); // R6

  AST_BYTE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && !act_ch[CHW-1]) |-> (mem_addr[OFFW-1:0] == mem_off)); // R5
endmodule

// File: rtl/dar_eop_fanout.sv
module dar_eop_fanout #(
  parameter int unsigned NCH  = 8,
  localparam int unsigned CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ctl_eop,
  input  logic [NCH-1:0] eop_en,
  input  logic           act_valid,
  input  logic [CHW-1:0] act_ch,
  output logic [NCH-1:0] bus_eop
);
  logic           cur_eop;
  logic [NCH-1:0] eop_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_eop <= 1'b0;
    end else begin
      cur_eop <= ctl_eop;
    end
  end

  for (genvar g = 0; g < int'(NCH); g++) begin : g_lane
    always_comb begin
      eop_d[g] = cur_eop && act_valid && (act_ch == CHW'(g)) && eop_en[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bus_eop[g] <= 1'b0;
      end else begin
        bus_eop[g] <= eop_d[g];
      end
    end
  end

  AST_EOP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_eop)); // R7

  AST_EOP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_eop != '0) |-> ($past(act_valid) && bus_eop[$past(act_ch)])); // R7

  AST_EOP_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_eop |=> (bus_eop == '0)); // R8
endmodule

// File: rtl/dma_ack_router.sv
module dma_ack_router
  import dar_pkg::*;
#(
  parameter int unsigned NCH     = DAR_NCH,
  parameter int unsigned CASCADE = DAR_CASCADE,
  parameter int unsigned PGW     = 8,
  parameter int unsigned OFFW    = 16,
  parameter int unsigned DW      = 8,
  localparam int unsigned CHW    = $clog2(NCH),
  localparam int unsigned AW     = PGW + OFFW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  dack_n,
  output logic            hold_ack,
  input  logic            pg_we,
  input  logic [CHW-1:0]  pg_addr,
  input  logic [PGW-1:0]  pg_wdata,
  input  logic [OFFW-1:0] mem_off,
  input  logic            mem_rd_req,
  input  logic            mem_wr_req,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_rd_en,
  output logic            mem_wr_en,
  output logic [DW-1:0]   dma_rdata,
  input  logic            ctl_eop,
  input  logic [NCH-1:0]  eop_en,
  output logic [NCH-1:0]  bus_eop,
  output logic            act_valid,
  output logic [CHW-1:0]  act_ch
);
  localparam logic [DW-1:0] IDLE_RD = {DW{1'b1}};

  logic [1:0] rst_sync;
  logic       rst_sn;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= '0;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_sn = rst_sync[1];

  assign hold_ack = ~dack_n[CASCADE];

  dar_chan_track #(.NCH(NCH), .CASCADE(CASCADE)) u_track (
    .clk       (clk),
    .rst_n     (rst_sn),
    .dack_n    (dack_n),
    .act_valid (act_valid),
    .act_ch    (act_ch)
  );

  dar_page_file #(.NCH(NCH), .PGW(PGW), .OFFW(OFFW)) u_pages (
    .clk       (clk),
    .rst_n     (rst_sn),
    .pg_we     (pg_we),
    .pg_addr   (pg_addr),
    .pg_wdata  (pg_wdata),
    .act_valid (act_valid),
    .act_ch    (act_ch),
    .mem_off   (mem_off),
    .mem_addr  (mem_addr)
  );

  dar_eop_fanout #(.NCH(NCH)) u_eop (
    .clk       (clk),
    .rst_n     (rst_sn),
    .ctl_eop   (ctl_eop),
    .eop_en    (eop_en),
    .act_valid (act_valid),
    .act_ch    (act_ch),
    .bus_eop   (bus_eop)
  );

  // neutralise accesses while the bus has no owner
  always_comb begin
    mem_rd_en = mem_rd_req && act_valid;
    mem_wr_en = mem_wr_req && act_valid;
    dma_rdata = act_valid ? mem_rdata_i : IDLE_RD;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_sn)
    !act_valid |-> (!mem_rd_en && !mem_wr_en && dma_rdata == IDLE_RD)); // R4

  AST_EOP_NEEDS_OWNER: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_eop != '0) |-> $past(act_valid)); // R7
endmodule

// File: tb/dma_ack_router_bench.sv
module dma_ack_router_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  dack_n;
  logic        hold_ack;
  logic        pg_we;
  logic [2:0]  pg_addr;
  logic [7:0]  pg_wdata;
  logic [15:0] mem_off;
  logic        mem_rd_req;
  logic        mem_wr_req;
  logic [7:0]  mem_rdata_i;
  logic [23:0] mem_addr;
  logic        mem_rd_en;
  logic        mem_wr_en;
  logic [7:0]  dma_rdata;
  logic        ctl_eop;
  logic [7:0]  eop_en;
  logic [7:0]  bus_eop;
  logic        act_valid;
  logic [2:0]  act_ch;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dma_ack_router u_dma_ack_router (
    .clk(clk), .rst_n(rst_n), .dack_n(dack_n), .hold_ack(hold_ack),
    .pg_we(pg_we), .pg_addr(pg_addr), .pg_wdata(pg_wdata),
    .mem_off(mem_off), .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req),
    .mem_rdata_i(mem_rdata_i), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .dma_rdata(dma_rdata), .ctl_eop(ctl_eop),
    .eop_en(eop_en), .bus_eop(bus_eop), .act_valid(act_valid), .act_ch(act_ch)
  );

  // {channel, page, offset, expected address}
  localparam logic [50:0] VEC [7] = '{
    {3'd0, 8'h12, 16'h3456, 24'h123456},
    {3'd3, 8'hFE, 16'hFFFF, 24'hFEFFFF},
    {3'd1, 8'h00, 16'h0001, 24'h000001},
    {3'd5, 8'h13, 16'h1234, 24'h122468},
    {3'd6, 8'hFF, 16'hFFFF, 24'hFFFFFE},
    {3'd7, 8'h80, 16'h8000, 24'h810000},
    {3'd2, 8'hA5, 16'h0000, 24'hA50000}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr_page(input logic [2:0] a, input logic [7:0] d);
    pg_we = 1'b1; pg_addr = a; pg_wdata = d;
    step(1);
    pg_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung expected finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; dack_n = 8'hFF; pg_we = 1'b0; pg_addr = '0; pg_wdata = '0;
    mem_off = '0; mem_rd_req = 1'b0; mem_wr_req = 1'b0; mem_rdata_i = '0;
    ctl_eop = 1'b0; eop_en = 8'hFF;
    step(3);
    rst_n = 1'b1;
    step(4);

    // R1 reset state
    chk("R1 valid", 32'(act_valid), 32'd0);
    chk("R1 eop", 32'(bus_eop), 32'd0);
    chk("R1 rdata", 32'(dma_rdata), 32'hFF);
    dack_n[0] = 1'b0; mem_off = 16'h00AB;
    step(1);
    chk("R1 page zero", 32'(mem_addr), 32'h0000AB);
    dack_n[0] = 1'b1;
    step(1);

    // R4 idle access
    mem_rd_req = 1'b1; mem_wr_req = 1'b1; mem_rdata_i = 8'h3C;
    #1;
    chk("R4 rd gated", 32'(mem_rd_en), 32'd0);
    chk("R4 wr gated", 32'(mem_wr_en), 32'd0);
    chk("R4 idle rdata", 32'(dma_rdata), 32'hFF);
    mem_wr_req = 1'b0;

    // R5 R6 R11 address vectors
    for (int k = 0; k < 7; k++) begin
      logic [2:0]  ch;
      logic [7:0]  pg;
      logic [15:0] off;
      logic [23:0] ea;
      {ch, pg, off, ea} = VEC[k];
      wr_page({ch[2], ch[1:0]}, pg);
      mem_off = off; mem_rdata_i = 8'(k + 1); dack_n[ch] = 1'b0;
      step(1);
      chk("R2 active", 32'({act_valid, act_ch}), 32'({1'b1, ch}));
      chk(ch[2] ? "R6 word addr" : "R5 byte addr", 32'(mem_addr), 32'(ea));
      chk("R4 rd pass", 32'({mem_rd_en, dma_rdata}), 32'({1'b1, 8'(k + 1)}));
      dack_n[ch] = 1'b1;
      step(1);
      chk("R3 released", 32'(act_valid), 32'd0);
    end
    mem_rd_req = 1'b0;

    // R11 word bank write must not touch byte channel 1 (page 00)
    wr_page(3'b101, 8'h44);
    dack_n[1] = 1'b0; mem_off = 16'h0010;
    step(1);
    chk("R11 bank select", 32'(mem_addr), 32'h000010);
    dack_n[1] = 1'b1;
    step(1);

    // R4 write passes with an owner
    dack_n[2] = 1'b0; mem_wr_req = 1'b1;
    step(1);
    chk("R4 wr pass", 32'(mem_wr_en), 32'd1);
    dack_n[2] = 1'b1; mem_wr_req = 1'b0;
    step(1);

    // R2 lowest wins, R3 foreign release ignored
    dack_n[1] = 1'b0; dack_n[2] = 1'b0;
    step(1);
    chk("R2 lowest", 32'({act_valid, act_ch}), 32'h9);
    dack_n[2] = 1'b1;
    step(1);
    chk("R3 other release", 32'({act_valid, act_ch}), 32'h9);
    dack_n[1] = 1'b1;
    step(1);
    chk("R3 held release", 32'(act_valid), 32'd0);

    // R10 cascade
    dack_n[4] = 1'b0;
    #1;
    chk("R10 hold_ack", 32'(hold_ack), 32'd1);
    step(1);
    chk("R10 untracked", 32'(act_valid), 32'd0);
    dack_n[4] = 1'b1; step(1);
    dack_n[4] = 1'b0; dack_n[6] = 1'b0;
    step(1);
    chk("R10 cascade skipped", 32'({act_valid, act_ch}), 32'hE);
    dack_n[4] = 1'b1; dack_n[6] = 1'b1;
    #1;
    chk("R10 hold_ack low", 32'(hold_ack), 32'd0);
    step(2);

    // R7 forwarding and latency
    dack_n[3] = 1'b0;
    step(2);
    chk("R7 no flag", 32'(bus_eop), 32'd0);
    ctl_eop = 1'b1;
    step(1);
    chk("R7 latency", 32'(bus_eop), 32'd0);
    step(1);
    chk("R7 forward", 32'(bus_eop), 32'h08);
    // R8 release deasserts, late ack replays
    dack_n[3] = 1'b1;
    step(1);
    chk("R8 release edge1", 32'(bus_eop), 32'h08);
    step(1);
    chk("R8 release", 32'(bus_eop), 32'd0);
    dack_n[6] = 1'b0;
    step(1);
    chk("R8 replay edge1", 32'(bus_eop), 32'd0);
    step(1);
    chk("R8 replay", 32'(bus_eop), 32'h40);
    // R9 enable gating
    eop_en[6] = 1'b0;
    step(1);
    chk("R9 disabled", 32'(bus_eop), 32'd0);
    eop_en = 8'hFF;
    step(1);
    chk("R9 reenabled", 32'(bus_eop), 32'h40);
    dack_n[6] = 1'b1; ctl_eop = 1'b0;
    step(3);
    chk("R7 idle", 32'(bus_eop), 32'd0);

    done = 1'b1;
    finish_run();
  end
endmodule